// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This block holds the instruction address of a small controller with an 11-bit address space that is split into four 512-word pages. Each instruction cycle in which `step` is high, it works out the next address from an instruction class: sequential advance, long jump, subroutine call, write to the low address byte, or subroutine return.

The two top address bits never come from the instruction. For jumps, calls and low-byte writes they come from a two-bit page preselect value that the status register supplies. Calls and low-byte writes also force address bit 8 to zero, so call targets and computed jumps reach only the lower half of a page.

A hardware return stack keeps the two most recent return addresses at full width. It never reports empty. A pop duplicates the bottom entry, so repeated returns keep producing the oldest value that is still held. On each return a one-cycle strobe tells the surrounding datapath that the return literal may be loaded.

Top module: `pc_stack_unit`

## Requirements
- R1: With `step` high and class 0 (sequential), `pc` becomes `pc`+1 modulo 2^11 on the next edge. Crossing from x1FF into x200 moves to the next page regardless of `page_sel`, and 7FF wraps to 000.
- R2: With `step` high and class 1 (jump), `pc` becomes {`page_sel`, `addr_fld[8:0]`}.
- R3: With `step` high and class 2 (call), `pc` becomes {`page_sel`, 0, `addr_fld[7:0]`}, so bit 8 is always 0.
- R4: With `step` high and class 3 (low-byte write), `pc` becomes {`page_sel`, 0, `low_data[7:0]`}.
- R5: While `rst_n` is low, `pc` is 7FF, both stack levels are 000 and `ret_valid` is 0.
- R6: A call moves `stk_top` into `stk_bot` and writes the pre-call `pc`+1 into `stk_top`.
- R7: After more than two nested calls, only the two most recent return addresses are held; older ones are lost.
- R8: With `step` high and class 4 (return), `pc` takes `stk_top`, `stk_top` takes `stk_bot`, and `stk_bot` is unchanged, so further returns keep yielding the old `stk_bot`.
- R9: A return restores all 11 bits, page bits included, whatever `page_sel` is.
- R10: `ret_valid` is high for exactly the one cycle that follows each return step and is low otherwise.
- R11: With `step` low, `pc`, `stk_top` and `stk_bot` are unchanged whatever the other inputs are.
- R12: Class codes 5, 6 and 7 behave as class 0 (sequential) and leave the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction cycle enable |
| op | input | 3 | Instruction class (0 seq, 1 jump, 2 call, 3 low write, 4 return) |
| addr_fld | input | 9 | Address field of the instruction |
| low_data | input | 8 | Data written to the low address byte |
| page_sel | input | 2 | Page preselect bits from the status register |
| pc | output | 11 | Current program counter |
| stk_top | output | 11 | Stack level 1 (next return address) |
| stk_bot | output | 11 | Stack level 2 |
| ret_valid | output | 1 | One-cycle strobe after a return |

## Verification
Every result lives in a register that is one edge away from its stimulus. `pc`, both stack levels and `ret_valid` are therefore all due at the first rising edge after the inputs are applied. The bench drives its inputs on the falling edge and samples 1 ns after the next rising edge. At that point it compares all four outputs against a model that it updates once per applied step. The `ret_valid` strobe is checked in the cycle after a return and again one idle cycle later, which confirms that the pulse lasts exactly one cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   typedef enum logic [2:0] {
      OP_SEQ   = 3'd0,
      OP_JUMP  = 3'd1,
      OP_CALL  = 3'd2,
      OP_LOWWR = 3'd3,
      OP_RET   = 3'd4
   } pc_op_e;
endpackage

// File: rtl/pc_next_sel.sv
module pc_next_sel #(
   parameter int PC_W   = 11,
   parameter int PAGE_W = 2,
   parameter int LOW_W  = 8
) (
   input  logic [2:0]             op,
   input  logic [PC_W-1:0]        pc_cur,
   input  logic [PC_W-PAGE_W-1:0] addr_fld,
   input  logic [LOW_W-1:0]       low_data,
   input  logic [PAGE_W-1:0]      page_sel,
   input  logic [PC_W-1:0]        ret_addr,
   output logic [PC_W-1:0]        pc_nxt,
   output logic [PC_W-1:0]        pc_inc,
   output logic                   push,
   output logic                   pop
);
   import pcs_pkg::*;

   localparam int OFS_W = PC_W - PAGE_W;
   localparam int PAD_W = OFS_W - LOW_W;

   logic [PC_W-1:0] near_tgt_call;
   logic [PC_W-1:0] near_tgt_low;
   logic [PC_W-1:0] far_tgt;

   assign pc_inc  = pc_cur + PC_W'(1);
   assign far_tgt = {page_sel, addr_fld};

   generate
      if (PAD_W >= 1) begin : g_pad
         assign near_tgt_call = {page_sel, {PAD_W{1'b0}}, addr_fld[LOW_W-1:0]};
         assign near_tgt_low  = {page_sel, {PAD_W{1'b0}}, low_data};
      end else begin : g_nopad
         assign near_tgt_call = {page_sel, addr_fld[OFS_W-1:0]};
         assign near_tgt_low  = {page_sel, low_data[OFS_W-1:0]};
      end
   endgenerate

   always_comb begin
      push   = 1'b0;
      pop    = 1'b0;
      pc_nxt = pc_inc;
      case (op)
         OP_JUMP:  pc_nxt = far_tgt;
         OP_CALL: begin
            pc_nxt = near_tgt_call;
            push   = 1'b1;
         end
         OP_LOWWR: pc_nxt = near_tgt_low;
         OP_RET: begin
            pc_nxt = ret_addr;
            pop    = 1'b1;
         end
         default:  pc_nxt = pc_inc;
      endcase
   end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
   parameter int W     = 11,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_val,
   output logic [W-1:0] top,
   output logic [W-1:0] bot
);
   logic [W-1:0] lvl [DEPTH];

   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_lvl
         logic [W-1:0] from_above;
         logic [W-1:0] from_below;
         if (i == 0) begin : g_first
            assign from_above = push_val;
         end else begin : g_inner
            assign from_above = lvl[i-1];
         end
         if (i == DEPTH-1) begin : g_last
            assign from_below = lvl[i];
         end else begin : g_mid
            assign from_below = lvl[i+1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)    lvl[i] <= '0;
            else if (push) lvl[i] <= from_above;
            else if (pop)  lvl[i] <= from_below;
         end
      end
   endgenerate

   assign top = lvl[0];
   assign bot = lvl[DEPTH-1];
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
   parameter int PC_W   = 11,
   parameter int PAGE_W = 2,
   parameter int LOW_W  = 8,
   parameter int DEPTH  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   step,
   input  logic [2:0]             op,
   input  logic [PC_W-PAGE_W-1:0] addr_fld,
   input  logic [LOW_W-1:0]       low_data,
   input  logic [PAGE_W-1:0]      page_sel,
   output logic [PC_W-1:0]        pc,
   output logic [PC_W-1:0]        stk_top,
   output logic [PC_W-1:0]        stk_bot,
   output logic                   ret_valid
);
   localparam int OFS_W = PC_W - PAGE_W;

   generate
      if (LOW_W > OFS_W) begin : g_bad_low
         $error("LOW_W must not exceed the in-page offset width");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (PAGE_W < 1 || OFS_W < 2) begin : g_bad_page
         $error("PAGE_W must leave room for an in-page offset");
      end
   endgenerate

   logic [PC_W-1:0] pc_nxt;
   logic [PC_W-1:0] pc_inc;
   logic            push_req;
   logic            pop_req;

   pc_next_sel #(.PC_W(PC_W), .PAGE_W(PAGE_W), .LOW_W(LOW_W)) u_sel (
      .op       (op),
      .pc_cur   (pc),
      .addr_fld (addr_fld),
      .low_data (low_data),
      .page_sel (page_sel),
      .ret_addr (stk_top),
      .pc_nxt   (pc_nxt),
      .pc_inc   (pc_inc),
      .push     (push_req),
      .pop      (pop_req)
   );

   ret_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (step & push_req),
      .pop      (step & pop_req),
      .push_val (pc_inc),
      .top      (stk_top),
      .bot      (stk_bot)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc        <= '1;
         ret_valid <= 1'b0;
      end else begin
         if (step) pc <= pc_nxt;
         ret_valid <= step & pop_req;
      end
   end
endmodule

// File: rtl/pc_stack_chk.sv
module pc_stack_chk #(
   parameter int PC_W   = 11,
   parameter int PAGE_W = 2,
   parameter int LOW_W  = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   step,
   input logic [2:0]             op,
   input logic [PC_W-PAGE_W-1:0] addr_fld,
   input logic [LOW_W-1:0]       low_data,
   input logic [PAGE_W-1:0]      page_sel,
   input logic [PC_W-1:0]        pc,
   input logic [PC_W-1:0]        stk_top,
   input logic [PC_W-1:0]        stk_bot,
   input logic                   ret_valid
);
   localparam int OFS_W = PC_W - PAGE_W;

   a_r1_seq_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (step && op == 3'd0) |=> pc == $past(pc) + PC_W'(1));

   a_r2_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
      (step && op == 3'd1) |=> pc == {$past(page_sel), $past(addr_fld)});

   a_r3_call_bit8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && op == 3'd2) |=> (pc[OFS_W-1] == 1'b0 &&
                                pc[PC_W-1:OFS_W] == $past(page_sel)));

   a_r4_low_write: assert property (@(posedge clk) disable iff (!rst_n)
      (step && op == 3'd3) |=> pc[LOW_W-1:0] == $past(low_data));

   a_r6_call_push: assert property (@(posedge clk) disable iff (!rst_n)
      (step && op == 3'd2) |=> (stk_top == $past(pc) + PC_W'(1) &&
                                stk_bot == $past(stk_top)));

   a_r8_ret_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (step && op == 3'd4) |=> (pc == $past(stk_top) &&
                                stk_top == $past(stk_bot) && $stable(stk_bot)));

   a_r10_strobe_after_ret: assert property (@(posedge clk) disable iff (!rst_n)
      (step && op == 3'd4) |=> ret_valid);

   a_r10_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && op == 3'd4) |=> !ret_valid);

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(pc) && $stable(stk_top) && $stable(stk_bot)));

   a_r12_unused_stack: assert property (@(posedge clk) disable iff (!rst_n)
      (step && op > 3'd4) |=> ($stable(stk_top) && $stable(stk_bot)));
endmodule

bind pc_stack_unit pc_stack_chk #(.PC_W(PC_W), .PAGE_W(PAGE_W), .LOW_W(LOW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .step(step), .op(op), .addr_fld(addr_fld),
   .low_data(low_data), .page_sel(page_sel), .pc(pc), .stk_top(stk_top),
   .stk_bot(stk_bot), .ret_valid(ret_valid)
);

// File: tb/pc_stack_unit_tb.sv
module pc_stack_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [8:0]  addr_fld = '0;
   logic [7:0]  low_data = '0;
   logic [1:0]  page_sel = '0;
   logic [10:0] pc, stk_top, stk_bot;
   logic        ret_valid;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [10:0] e_pc = 11'h7FF, e_top = '0, e_bot = '0;
   logic        e_rv = 1'b0;

   always #10 clk = ~clk;

   pc_stack_unit u_dut (
      .clk(clk), .rst_n(rst_n), .step(step), .op(op), .addr_fld(addr_fld),
      .low_data(low_data), .page_sel(page_sel), .pc(pc), .stk_top(stk_top),
      .stk_bot(stk_bot), .ret_valid(ret_valid)
   );

   task automatic compare(input string tag);
      n_chk++;
      if (pc !== e_pc || stk_top !== e_top || stk_bot !== e_bot || ret_valid !== e_rv) begin
         n_fail++;
         $display("FAIL %s: pc/top/bot/rv actual %h/%h/%h/%b expected %h/%h/%h/%b",
                  tag, pc, stk_top, stk_bot, ret_valid, e_pc, e_top, e_bot, e_rv);
      end
   endtask

   task automatic apply(input logic s, input logic [2:0] o, input logic [8:0] a,
                        input logic [7:0] d, input logic [1:0] p, input string tag);
      logic [10:0] inc;
      @(negedge clk);
      step = s; op = o; addr_fld = a; low_data = d; page_sel = p;
      inc  = e_pc + 11'd1;
      e_rv = s && (o == 3'd4);
      if (s) begin
         case (o)
            3'd1: e_pc = {p, a};
            3'd2: begin e_bot = e_top; e_top = inc; e_pc = {p, 1'b0, a[7:0]}; end
            3'd3: e_pc = {p, 1'b0, d};
            3'd4: begin e_pc = e_top; e_top = e_bot; end
            default: e_pc = inc;
         endcase
      end
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 compare("R5 reset state");
      @(negedge clk); rst_n = 1'b1;

      apply(1, 3'd0, 9'h000, 8'h00, 2'b10, "R1 wrap 7FF to 000");
      apply(1, 3'd1, 9'h1FE, 8'h00, 2'b00, "R2 jump to 1FE");
      apply(1, 3'd0, 9'h000, 8'h00, 2'b00, "R1 seq 1FF");
      apply(1, 3'd0, 9'h000, 8'h00, 2'b00, "R1 page rollover 200");
      apply(1, 3'd1, 9'h0AB, 8'h00, 2'b00, "R2 goto after rollover back to page 0");

      for (int pg = 0; pg < 4; pg++)
         for (int a = 0; a < 512; a += 3)
            apply(1, 3'd1, 9'(a), 8'h00, 2'(pg), "R2 jump sweep");

      for (int pg = 0; pg < 4; pg++)
         for (int d = 0; d < 256; d++)
            apply(1, 3'd3, 9'h1FF, 8'(d), 2'(pg), "R4 low write sweep");

      apply(1, 3'd1, 9'h1F0, 8'h00, 2'b11, "R2 jump page 3");
      apply(1, 3'd2, 9'h1C4, 8'h00, 2'b01, "R3 R6 call one");
      apply(1, 3'd2, 9'h155, 8'h00, 2'b10, "R3 R6 call two");
      apply(1, 3'd2, 9'h1FF, 8'h00, 2'b00, "R7 call three drops oldest");
      apply(1, 3'd4, 9'h000, 8'h00, 2'b00, "R8 R10 return one");
      apply(0, 3'd4, 9'h000, 8'h00, 2'b00, "R10 strobe ends R11 idle");
      apply(1, 3'd4, 9'h000, 8'h00, 2'b11, "R8 R9 return two full width");
      apply(1, 3'd4, 9'h000, 8'h00, 2'b01, "R8 return three repeats bottom");
      apply(1, 3'd4, 9'h000, 8'h00, 2'b10, "R8 return four repeats bottom");

      for (int k = 0; k < 64; k++) begin
         apply(1, 3'd1, 9'(k * 7 + 256), 8'h00, 2'(k), "R2 setup");
         apply(1, 3'd2, 9'(k * 4), 8'h00, 2'(k + 1), "R3 R6 call sweep");
         apply(1, 3'd2, 9'(k * 5 + 1), 8'h00, 2'(k + 2), "R6 call sweep nested");
         apply(1, 3'd4, 9'h000, 8'h00, 2'(k + 3), "R8 R9 return sweep");
         apply(1, 3'd4, 9'h000, 8'h00, 2'(k), "R8 R9 return sweep outer");
      end

      for (int o = 0; o < 8; o++)
         apply(0, 3'(o), 9'h0F0, 8'h3C, 2'b11, "R11 idle hold");

      apply(1, 3'd5, 9'h0F0, 8'h3C, 2'b11, "R12 code 5 sequential");
      apply(1, 3'd6, 9'h0F0, 8'h3C, 2'b10, "R12 code 6 sequential");
      apply(1, 3'd7, 9'h0F0, 8'h3C, 2'b01, "R12 code 7 sequential");

      @(negedge clk); rst_n = 1'b0; step = 1'b0;
      e_pc = 11'h7FF; e_top = '0; e_bot = '0; e_rv = 1'b0;
      @(posedge clk); #1 compare("R5 reset again");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule